// File: doc/BRIEF.md
# Wake Event Enable Router

This block takes eight pending wake-event status bits and decides, through two software-programmed enable masks, which system wake outputs they drive. The routing mask sends each enabled, pending event to either the system control interrupt (SCI) or the power-on request (POR). One mode input picks which of the two. The direct mask sends enabled, pending events to POR whatever the mode input says. Any event that passes the routing mask also drives a power-on control output.

A host reaches the two masks and a one-byte command register through a small byte-offset register port. The command register stores its value and has no effect on routing. Every write to it sets a sticky flag, and that flag also requests power-on. A clear input pulse drops the flag. The event status bits and the mode bit arrive already captured, because status capture and clearing happen outside this block. All three wake outputs are registered once.

Top module: `wake_router`

## Requirements
- R1: A synchronous active-high reset clears both masks, the command register, the sticky flag, rdata_o, sci_o, por_o and onctl_o to 0.
- R2: The routing mask sits at offset 4h and the direct mask at offset 8h. Each is written on a cycle with wr_en high and read back on rdata_o one cycle after a cycle with rd_en high.
- R3: Offsets 5h, 6h and 7h, and every other unmapped offset, read as 0. Writes to them change no mask, no command value and no flag.
- R4: With sci_mode=1, any bit set in both the routing mask and evt_status drives sci_o high one clock after the inputs are seen. With no such bit, sci_o is low.
- R5: With sci_mode=0, routing-mask events drive por_o instead, and sci_o stays low.
- R6: Any bit set in both the direct mask and evt_status drives por_o one clock later, for either value of sci_mode. It never drives sci_o.
- R7: onctl_o goes high one clock after any bit is set in both the routing mask and evt_status, for either value of sci_mode.
- R8: Bit i of evt_status pairs only with bit i of each mask. The order is: bit0 first power-management event, bit1 second power-management event, bit2 first infrared receive, bit3 second infrared receive, bits 4, 5 and 6 three general-purpose pins, bit7 keyboard-controller line.
- R9: The command register at offset Ch reads back the last value written to it. Its value has no effect on sci_o or onctl_o.
- R10: Any write to offset Ch sets cmd_flag_o on the next clock. While the flag is set, por_o is high one clock later. A cmd_clr pulse clears the flag. A command write in the same cycle as cmd_clr leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | N_EVT | Write data |
| rdata_o | output | N_EVT | Registered read data |
| evt_status | input | N_EVT | Captured wake-event status bits |
| sci_mode | input | 1 | 1 routes the routing mask to SCI, 0 routes it to POR |
| cmd_clr | input | 1 | Clear pulse for the sticky command flag |
| sci_o | output | 1 | System control interrupt request |
| por_o | output | 1 | Power-on request |
| onctl_o | output | 1 | Power-on control |
| cmd_flag_o | output | 1 | Sticky command-write flag |

## Verification
The assertions check on every cycle the following rules:
- sci_o appears only when the mode selected SCI and a routing-mask term was pending.
- sci_o is always joined by onctl_o.
- A command write raises the flag, and the flag falls only on a clear that did not collide with a write.
- A raised flag forces POR.
- Reserved offsets read 0.

Only the bench's scenarios can show the following:
- The exact bit pairing for each event.
- Routing through the direct mask alone.
- Reads returning what was written.
- Writes to reserved offsets leaving every register untouched.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // Byte offsets decoded by the register port
  localparam logic [7:0] OFS_ROUTE_MASK  = 8'h04;
  localparam logic [7:0] OFS_RSV_LO      = 8'h05;
  localparam logic [7:0] OFS_RSV_HI      = 8'h07;
  localparam logic [7:0] OFS_DIRECT_MASK = 8'h08;
  localparam logic [7:0] OFS_COMMAND     = 8'h0C;

  typedef struct packed {
    logic sci;
    logic por;
    logic onctl;
  } wake_out_t;
endpackage

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int N_EVT  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_EVT-1:0]  wdata,
  input  logic              cmd_clr,
  output logic [N_EVT-1:0]  route_mask,
  output logic [N_EVT-1:0]  direct_mask,
  output logic              cmd_flag,
  output logic [N_EVT-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFS_ROUTE_MASK);
  localparam logic [ADDR_W-1:0] A_DIRECT = ADDR_W'(OFS_DIRECT_MASK);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_COMMAND);

  logic [N_EVT-1:0] cmd_val;
  logic             hit_route, hit_direct, hit_cmd;
  logic [N_EVT-1:0] rd_mux;

  assign hit_route  = (addr == A_ROUTE);
  assign hit_direct = (addr == A_DIRECT);
  assign hit_cmd    = (addr == A_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      route_mask  <= '0;
      direct_mask <= '0;
      cmd_val     <= '0;
    end else if (wr_en) begin
      if (hit_route)  route_mask  <= wdata;
      if (hit_direct) direct_mask <= wdata;
      if (hit_cmd)    cmd_val     <= wdata;
    end
  end

  // Sticky flag: a write wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)                    cmd_flag <= 1'b0;
    else if (wr_en && hit_cmd)  cmd_flag <= 1'b1;
    else if (cmd_clr)           cmd_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_route)  rd_mux = route_mask;
    if (hit_direct) rd_mux = direct_mask;
    if (hit_cmd)    rd_mux = cmd_val;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/wake_route.sv
module wake_route #(
  parameter int N_EVT = 8
) (
  input  logic [N_EVT-1:0] status,
  input  logic [N_EVT-1:0] route_mask,
  input  logic [N_EVT-1:0] direct_mask,
  output logic             any_route,
  output logic             any_direct
);
  logic [N_EVT-1:0] route_term, direct_term;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    assign route_term[i]  = route_mask[i]  & status[i];
    assign direct_term[i] = direct_mask[i] & status[i];
  end

  assign any_route  = |route_term;
  assign any_direct = |direct_term;
endmodule

// File: rtl/wake_router.sv
module wake_router
  import wake_pkg::*;
#(
  parameter int N_EVT  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_EVT-1:0]  wdata,
  output logic [N_EVT-1:0]  rdata_o,
  input  logic [N_EVT-1:0]  evt_status,
  input  logic              sci_mode,
  input  logic              cmd_clr,
  output logic              sci_o,
  output logic              por_o,
  output logic              onctl_o,
  output logic              cmd_flag_o
);
  logic [N_EVT-1:0] route_mask, direct_mask;
  logic             cmd_flag, any_route, any_direct;
  wake_out_t        nxt, cur;

  wake_regs #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cmd_clr(cmd_clr), .route_mask(route_mask),
    .direct_mask(direct_mask), .cmd_flag(cmd_flag), .rdata(rdata_o)
  );

  wake_route #(.N_EVT(N_EVT)) route_i (
    .status(evt_status), .route_mask(route_mask), .direct_mask(direct_mask),
    .any_route(any_route), .any_direct(any_direct)
  );

  always_comb begin
    nxt.sci   = any_route & sci_mode;
    nxt.por   = (any_route & ~sci_mode) | any_direct | cmd_flag;
    nxt.onctl = any_route;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign sci_o      = cur.sci;
  assign por_o      = cur.por;
  assign onctl_o    = cur.onctl;
  assign cmd_flag_o = cmd_flag;
endmodule

// File: rtl/wake_router_chk.sv
module wake_router_chk #(
  parameter int N_EVT  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_EVT-1:0]  rdata_o,
  input logic [N_EVT-1:0]  evt_status,
  input logic [N_EVT-1:0]  route_mask,
  input logic              sci_mode,
  input logic              cmd_clr,
  input logic              sci_o,
  input logic              por_o,
  input logic              onctl_o,
  input logic              cmd_flag_o
);
  logic cmd_wr, rsv_rd;
  assign cmd_wr = wr_en && (addr == ADDR_W'(8'h0C));
  assign rsv_rd = rd_en && (addr >= ADDR_W'(8'h05)) && (addr <= ADDR_W'(8'h07));

  // R4
  sci_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sci_o |-> $past(sci_mode));

  // R5
  sci_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
    sci_o |-> $past(|(route_mask & evt_status)));

  // R7
  sci_with_onctl_chk: assert property (@(posedge clk) disable iff (rst)
    sci_o |-> onctl_o);

  // R10
  cmd_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> cmd_flag_o);

  // R10
  flag_falls_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_flag_o) |-> ($past(cmd_clr) && !$past(cmd_wr)));

  // R10
  flag_forces_por_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_flag_o |=> por_o);

  // R3
  reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsv_rd |=> (rdata_o == '0));
endmodule

bind wake_router wake_router_chk #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata_o(rdata_o), .evt_status(evt_status), .route_mask(route_mask),
  .sci_mode(sci_mode), .cmd_clr(cmd_clr), .sci_o(sci_o), .por_o(por_o),
  .onctl_o(onctl_o), .cmd_flag_o(cmd_flag_o)
);

// File: tb/wake_router_tb_top.sv
module wake_router_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, cmd_clr = 1'b0, sci_mode = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, evt_status = '0;
  logic [7:0] rdata_o;
  logic       sci_o, por_o, onctl_o, cmd_flag_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_route = '0, m_direct = '0, m_cmd = '0;
  logic       m_flag = 1'b0;

  always #4 clk = ~clk;

  wake_router dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata_o(rdata_o), .evt_status(evt_status),
    .sci_mode(sci_mode), .cmd_clr(cmd_clr), .sci_o(sci_o), .por_o(por_o),
    .onctl_o(onctl_o), .cmd_flag_o(cmd_flag_o)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h4:    return m_route;
      4'h8:    return m_direct;
      4'hC:    return m_cmd;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_sci();
    return sci_mode && |(m_route & evt_status);
  endfunction

  function automatic logic exp_por();
    return (!sci_mode && |(m_route & evt_status)) || |(m_direct & evt_status) || m_flag;
  endfunction

  function automatic logic exp_onctl();
    return |(m_route & evt_status);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic clr);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; cmd_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; cmd_clr = 1'b0;
    if (a == 4'h4) m_route = d;
    if (a == 4'h8) m_direct = d;
    if (a == 4'hC) begin m_cmd = d; m_flag = 1'b1; end
    else if (clr) m_flag = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); cmd_clr = 1'b1;
    @(negedge clk); cmd_clr = 1'b0; m_flag = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(req, rdata_o, exp_read(a));
  endtask

  // apply status/mode, let one edge register the outputs, compare
  task automatic drive_check(input logic [7:0] st, input logic md, input string req);
    @(negedge clk); evt_status = st; sci_mode = md;
    @(negedge clk);
    check({req, " sci"},   {7'd0, sci_o},   {7'd0, exp_sci()});
    check({req, " por"},   {7'd0, por_o},   {7'd0, exp_por()});
    check({req, " onctl"}, {7'd0, onctl_o}, {7'd0, exp_onctl()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 sci", {7'd0, sci_o}, 8'd0);
    check("R1 por", {7'd0, por_o}, 8'd0);
    check("R1 onctl", {7'd0, onctl_o}, 8'd0);
    check("R1 flag", {7'd0, cmd_flag_o}, 8'd0);
    check("R1 rdata", rdata_o, 8'd0);
    do_read(4'h4, "R1 route mask");
    do_read(4'h8, "R1 direct mask");
    do_read(4'hC, "R1 command");

    // R2: readback
    do_write(4'h4, 8'hA5, 1'b0); do_read(4'h4, "R2 route mask");
    do_write(4'h8, 8'h3C, 1'b0); do_read(4'h8, "R2 direct mask");

    // R8 with R4, R5, R6, R7: walking bit pairing
    for (int i = 0; i < 8; i++) begin
      do_write(4'h4, 8'(1 << i), 1'b0);
      do_write(4'h8, 8'h00, 1'b0);
      drive_check(8'(1 << i), 1'b1, "R4 R8 match sci");
      drive_check(8'(1 << i), 1'b0, "R5 R7 match por");
      drive_check(~8'(1 << i), 1'b1, "R8 other bits");
      do_write(4'h4, 8'h00, 1'b0);
      do_write(4'h8, 8'(1 << i), 1'b0);
      drive_check(8'(1 << i), 1'b1, "R6 R8 direct mode1");
      drive_check(8'(1 << i), 1'b0, "R6 direct mode0");
      drive_check(~8'(1 << i), 1'b0, "R8 direct other");
    end

    // R3: reserved and unmapped offsets
    do_write(4'h4, 8'h5A, 1'b0);
    do_write(4'h8, 8'hC3, 1'b0);
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 8 && a != 12) begin
        do_write(4'(a), 8'hFF, 1'b0);
        do_read(4'(a), "R3 unmapped read");
      end
    end
    do_read(4'h4, "R3 route unchanged");
    do_read(4'h8, "R3 direct unchanged");
    do_read(4'hC, "R3 command unchanged");
    check("R3 flag unchanged", {7'd0, cmd_flag_o}, 8'd0);

    // R9, R10: command register and sticky flag
    do_write(4'hC, 8'h77, 1'b0);
    do_read(4'hC, "R9 command readback");
    check("R10 flag set", {7'd0, cmd_flag_o}, 8'd1);
    drive_check(8'h00, 1'b1, "R10 flag drives por");
    drive_check(8'h5A, 1'b1, "R9 command no effect");
    do_clear();
    check("R10 flag cleared", {7'd0, cmd_flag_o}, 8'd0);
    drive_check(8'h00, 1'b1, "R10 por idle");
    do_write(4'hC, 8'h11, 1'b1);
    check("R10 write beats clear", {7'd0, cmd_flag_o}, 8'd1);
    do_clear();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [3:0] ra = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 1) == 1) ra = ($urandom_range(0, 1) == 1) ? 4'h4 : 4'h8;
        do_write(ra, 8'($urandom), 1'($urandom_range(0, 3) == 0));
      end else if (op == 1) begin
        do_read(4'($urandom_range(0, 15)), "R2 R3 random read");
      end else if (op == 2) begin
        if ($urandom_range(0, 7) == 0) do_write(4'hC, 8'($urandom), 1'b0);
        else if ($urandom_range(0, 3) == 0) do_clear();
      end
      drive_check(8'($urandom), 1'($urandom_range(0, 1)), "R4 R5 R6 R7 random");
      check("R10 random flag", {7'd0, cmd_flag_o}, {7'd0, m_flag});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule